// File: doc/BRIEF.md
# Ultra DMA Read-Burst Sender

This block is the device side of an Ultra DMA data-in burst. Once a word is waiting at its ready/valid input, it raises the DMA request. It then waits for the host to acknowledge. After that it drives the 16-bit data bus and starts sending.

Each word goes out with exactly one toggle of the device strobe. As a result, the rising and falling edges of the strobe both carry data. The host can pause the flow by dropping its ready line, and can end the burst by raising its stop line. The block keeps a running 16-bit CRC over every word it strobes. At the end of a burst it puts that CRC on the bus so the host can compare it with its own.

The host ready line comes in through a small synchronizer. Because of that, a few strobe edges may still go out after the host has paused. The number of those edges is bounded and stays within the skid the host must absorb. All outputs come straight from registers. The only exception is the input handshake `in_ready`.

Top module: `udma_din_tx`

## Requirements
- R1: During and immediately after reset: `dmarq` is 0, `dstrobe` is 1 (its idle level), and `dq_oe`, `crc_on_bus` and `in_ready` are 0.
- R2: When the block is idle and `in_valid` is sampled high on a clock edge, `dmarq` goes high after that edge. It stays high until the termination sequence of R8 releases it.
- R3: While `dmack` has not been sampled high together with a low `stop`, the block accepts no word, makes no strobe edge, and keeps `dq_oe` low. `dq_oe` rises on the edge that samples `dmack`=1 with `stop`=0.
- R4: Every word accepted on the input (`in_valid` and `in_ready` both high at a clock edge) appears on `dq_out` after that edge. In the same edge `dstrobe` toggles exactly once. No data edge occurs without an accepted word, and the words leave in input order.
- R5: A word is sent only when the host ready level, delayed by `RDY_SYNC_STAGES` (default 2) clock edges, is high. After `host_rdy` falls, at most three further strobe edges occur while it stays low.
- R6: While `in_valid` is low and `stop` is low, `dstrobe` does not change. The burst simply waits.
- R7: While `stop` is high, `in_ready` is 0. On the edge that samples `stop` high during a burst, `dstrobe` returns to 1. If it was low, this last rising edge carries no new word.
- R8: On the next edge, `dmarq` falls, `crc_on_bus` rises, and `dq_out` holds the final CRC. These stay until `dmack` is sampled low. On that edge, `dq_oe` and `crc_on_bus` fall.
- R9: The CRC uses the polynomial x^16+x^12+x^5+1 (0x1021), processed MSB first. It is seeded with 0x4ABA at the start of every burst and updated once for each strobed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 16 | Next word to send |
| in_valid | input | 1 | `in_data` holds a word |
| in_ready | output | 1 | Block takes the word at this edge |
| dmack | input | 1 | Host DMA acknowledge (active high) |
| stop | input | 1 | Host request to end the burst |
| host_rdy | input | 1 | Host can accept data (low pauses) |
| dmarq | output | 1 | DMA request to the host |
| dstrobe | output | 1 | Device data strobe; both edges carry words |
| dq_out | output | 16 | Data bus value (word, or CRC at the end) |
| dq_oe | output | 1 | Block is driving the data bus |
| crc_on_bus | output | 1 | `dq_out` currently holds the final CRC |

## Verification
The assertions assume the host follows the burst protocol. It keeps `stop` low until it wants the burst to end, then holds `stop` high until it has dropped `dmack`. It raises `dmack` only after it has seen `dmarq`. The source port holds `in_data` steady while `in_valid` is high and no handshake has taken place.

The stimulus changes inputs only a short time after the falling clock edge. Each scenario raises `dmack` after `dmarq`, pauses with `host_rdy` or by starving the input, and drops `dmack` only after the CRC has appeared. It then releases `stop` once the block is idle again.

// File: rtl/udma_pkg.sv
package udma_pkg;

    localparam int WORD_W = 16;

    localparam logic [WORD_W-1:0] CRC_POLY = 16'h1021;
    localparam logic [WORD_W-1:0] CRC_SEED = 16'h4ABA;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_REQ,
        PH_BURST,
        PH_RELEASE,
        PH_CRC
    } burst_phase_e;

    typedef struct packed {
        word_t word;
        logic  strobe;
        logic  drive;
        logic  crc_flag;
    } bus_drive_t;

    // One word folded into the CRC, one bit per step, MSB first.
    function automatic word_t crc_fold(input word_t acc, input word_t din);
        word_t c;
        logic  fb;
        c = acc;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            fb = c[WORD_W-1] ^ din[b];
            c  = {c[WORD_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/udma_rdy_sync.sv
module udma_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
        end
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    pipe[i] <= 1'b0;
                end else begin
                    pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    assign q = pipe[LAST];
endmodule

// File: rtl/udma_crc_acc.sv
module udma_crc_acc
    import udma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  seed,
    input  logic  upd,
    input  word_t din,
    output word_t crc
);
    word_t acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= CRC_SEED;
        end else if (seed) begin
            acc <= CRC_SEED;
        end else if (upd) begin
            acc <= crc_fold(acc, din);
        end
    end

    assign crc = acc;
endmodule

// File: rtl/udma_din_tx.sv
module udma_din_tx
    import udma_pkg::*;
#(
    parameter int RDY_SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              dmack,
    input  logic              stop,
    input  logic              host_rdy,
    output logic              dmarq,
    output logic              dstrobe,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              crc_on_bus
);
    burst_phase_e phase;
    bus_drive_t   bus_q;
    logic         req_q;
    logic         rdy_s;
    logic         take;
    logic         start;
    word_t        crc;

    udma_rdy_sync #(.STAGES(RDY_SYNC_STAGES)) u_rdy_sync (
        .clk (clk),
        .rst (rst),
        .d   (host_rdy),
        .q   (rdy_s)
    );

    assign start    = (phase == PH_REQ) && dmack && !stop;
    assign in_ready = (phase == PH_BURST) && !stop && rdy_s;
    assign take     = in_ready && in_valid;

    udma_crc_acc u_crc (
        .clk  (clk),
        .rst  (rst),
        .seed (start),
        .upd  (take),
        .din  (in_data),
        .crc  (crc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase          <= PH_IDLE;
            req_q          <= 1'b0;
            bus_q.word     <= '0;
            bus_q.strobe   <= 1'b1;
            bus_q.drive    <= 1'b0;
            bus_q.crc_flag <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (in_valid) begin
                        phase <= PH_REQ;
                        req_q <= 1'b1;
                    end
                end
                PH_REQ: begin
                    if (start) begin
                        phase       <= PH_BURST;
                        bus_q.drive <= 1'b1;
                    end
                end
                PH_BURST: begin
                    if (stop) begin
                        phase        <= PH_RELEASE;
                        bus_q.strobe <= 1'b1;
                    end else if (take) begin
                        bus_q.word   <= in_data;
                        bus_q.strobe <= ~bus_q.strobe;
                    end
                end
                PH_RELEASE: begin
                    phase          <= PH_CRC;
                    req_q          <= 1'b0;
                    bus_q.word     <= crc;
                    bus_q.crc_flag <= 1'b1;
                end
                PH_CRC: begin
                    if (!dmack) begin
                        phase          <= PH_IDLE;
                        bus_q.drive    <= 1'b0;
                        bus_q.crc_flag <= 1'b0;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign dmarq      = req_q;
    assign dstrobe    = bus_q.strobe;
    assign dq_out     = bus_q.word;
    assign dq_oe      = bus_q.drive;
    assign crc_on_bus = bus_q.crc_flag;
endmodule

// File: rtl/udma_din_tx_chk.sv
module udma_din_tx_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic dmack,
    input logic stop,
    input logic host_rdy,
    input logic dmarq,
    input logic dstrobe,
    input logic dq_oe,
    input logic crc_on_bus
);
    logic       strb_prev;
    logic [2:0] skid_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            strb_prev <= 1'b1;
            skid_cnt  <= '0;
        end else begin
            strb_prev <= dstrobe;
            if (host_rdy) begin
                skid_cnt <= '0;
            end else if (dstrobe != strb_prev && skid_cnt != 3'd7) begin
                skid_cnt <= skid_cnt + 3'd1;
            end
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dstrobe && !dmarq && !dq_oe && !crc_on_bus && !in_ready)); // R1

    AST_NO_ACK_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (!dq_oe && !dmack) |=> !dq_oe); // R3

    AST_EDGE_HAS_WORD: assert property (@(posedge clk) disable iff (rst)
        ((dstrobe != $past(dstrobe)) && !$past(stop)) |-> $past(in_ready && in_valid)); // R4

    AST_SKID_LIMIT: assert property (@(posedge clk) disable iff (rst)
        skid_cnt <= 3'd3); // R5

    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !stop) |=> $stable(dstrobe)); // R6

    AST_STOP_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        stop |-> !in_ready); // R7

    AST_CRC_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(dmarq) |-> (crc_on_bus && dq_oe && dstrobe)); // R8
endmodule

bind udma_din_tx udma_din_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .dmack      (dmack),
    .stop       (stop),
    .host_rdy   (host_rdy),
    .dmarq      (dmarq),
    .dstrobe    (dstrobe),
    .dq_oe      (dq_oe),
    .crc_on_bus (crc_on_bus)
);

// File: tb/udma_din_tx_bench.sv
module udma_din_tx_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        dmack = 1'b0;
    logic        stop = 1'b0;
    logic        host_rdy = 1'b0;
    logic        dmarq;
    logic        dstrobe;
    logic [15:0] dq_out;
    logic        dq_oe;
    logic        crc_on_bus;

    always #10 clk = ~clk;

    udma_din_tx u_udma_din_tx (
        .clk        (clk),
        .rst        (rst),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .dmack      (dmack),
        .stop       (stop),
        .host_rdy   (host_rdy),
        .dmarq      (dmarq),
        .dstrobe    (dstrobe),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe),
        .crc_on_bus (crc_on_bus)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    logic [15:0] src_q[$];
    logic [15:0] sent_q[$];
    logic [15:0] got_q[$];
    bit          gap = 1'b0;

    // reference model state
    int          m_st;
    bit          m_dmarq, m_strb, m_oe, m_cb, m_s0, m_s1, m_take, stop_smp;
    logic [15:0] m_dq, m_crc;
    bit          host_prev_strb = 1'b1;
    int          pause_edges = 0;

    function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [15:0] d);
        int v;
        v = int'(c ^ d);
        for (int i = 0; i < 16; i++) begin
            if ((v & 32'h8000) != 0) v = ((v << 1) ^ 32'h1021) & 32'hFFFF;
            else                     v = (v << 1) & 32'hFFFF;
        end
        return v[15:0];
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // cycle model, advanced on the same edge as the design
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_st = 0; m_dmarq = 0; m_strb = 1; m_oe = 0; m_cb = 0;
            m_dq = '0; m_crc = 16'h4ABA; m_s0 = 0; m_s1 = 0; stop_smp = 0;
        end else begin
            stop_smp = stop;
            m_take = (m_st == 2) && !stop && m_s1 && in_valid;
            case (m_st)
                0: if (in_valid) begin m_st = 1; m_dmarq = 1; end
                1: if (dmack && !stop) begin m_st = 2; m_oe = 1; m_crc = 16'h4ABA; end
                2: if (stop) begin
                       m_st = 3; m_strb = 1;
                   end else if (m_take) begin
                       m_dq = in_data; m_strb = !m_strb;
                       m_crc = crc_ref(m_crc, in_data);
                       void'(src_q.pop_front());
                   end
                3: begin m_st = 4; m_dmarq = 0; m_dq = m_crc; m_cb = 1; end
                default: if (!dmack) begin m_st = 0; m_oe = 0; m_cb = 0; end
            endcase
            m_s1 = m_s0;
            m_s0 = host_rdy;
        end
        if (cyc > 100000) begin
            n_err++;
            $display("FAIL R4 watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    // per-clock comparison and host-side capture
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2", "dmarq", 32'(dmarq), 32'(m_dmarq));
            chk("R4", "dstrobe", 32'(dstrobe), 32'(m_strb));
            chk("R3", "dq_oe", 32'(dq_oe), 32'(m_oe));
            chk("R8", "crc_on_bus", 32'(crc_on_bus), 32'(m_cb));
            chk("R5", "in_ready", 32'(in_ready), 32'((m_st == 2) && !stop && m_s1));
            if (m_oe) chk("R9", "dq_out", 32'(dq_out), 32'(m_dq));
        end
        if (dstrobe !== host_prev_strb) begin
            if (!stop_smp) got_q.push_back(dq_out);
            if (!host_rdy) pause_edges++;
        end
        if (host_rdy) pause_edges = 0;
        host_prev_strb = dstrobe;
    end

    // source port driver
    always @(negedge clk) begin
        #1;
        in_valid = !gap && (src_q.size() > 0);
        in_data  = (src_q.size() > 0) ? src_q[0] : 16'h0000;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic push_words(input int n, input logic [15:0] base);
        for (int i = 0; i < n; i++) begin
            src_q.push_back(base ^ 16'(i * 16'h1357));
            sent_q.push_back(base ^ 16'(i * 16'h1357));
        end
    endtask

    task automatic wait_got(input int n);
        int t;
        t = 0;
        while (got_q.size() < n && t < 500) begin step(1); t++; end
        chk("R4", "words reached host", 32'(got_q.size()), 32'(n));
    endtask

    task automatic finish_burst(input int nwords, input string tag);
        int t;
        logic [15:0] c;
        stop = 1'b1;
        t = 0;
        while (!crc_on_bus && t < 50) begin step(1); t++; end
        chk("R8", {tag, " crc phase reached"}, 32'(crc_on_bus), 32'd1);
        chk("R7", {tag, " strobe idle at end"}, 32'(dstrobe), 32'd1);
        chk("R8", {tag, " dmarq released"}, 32'(dmarq), 32'd0);
        chk("R4", {tag, " word count"}, 32'(got_q.size()), 32'(nwords));
        c = 16'h4ABA;
        for (int i = 0; i < got_q.size(); i++) begin
            chk("R4", {tag, " word order"}, 32'(got_q[i]), 32'(sent_q[i]));
            c = crc_ref(c, got_q[i]);
        end
        chk("R9", {tag, " final crc"}, 32'(dq_out), 32'(c));
        step(3);
        chk("R8", {tag, " crc held while acked"}, 32'(crc_on_bus), 32'd1);
        dmack = 1'b0;
        step(1);
        chk("R8", {tag, " bus released"}, 32'(dq_oe), 32'd0);
        stop = 1'b0;
        host_rdy = 1'b0;
        step(1);
        got_q.delete();
        sent_q.delete();
    endtask

    initial begin
        int sa;
        int sb;
        step(4);
        chk("R1", "dmarq in reset", 32'(dmarq), 32'd0);
        chk("R1", "dstrobe in reset", 32'(dstrobe), 32'd1);
        chk("R1", "dq_oe in reset", 32'(dq_oe), 32'd0);
        chk("R1", "in_ready in reset", 32'(in_ready), 32'd0);
        rst = 1'b0;
        step(2);
        chk("R1", "crc_on_bus after reset", 32'(crc_on_bus), 32'd0);

        // burst A: 4 words, request held without acknowledge
        push_words(4, 16'hA5C3);
        host_rdy = 1'b1;
        step(15);
        chk("R2", "request raised", 32'(dmarq), 32'd1);
        chk("R3", "no drive before ack", 32'(dq_oe), 32'd0);
        chk("R3", "no edge before ack", 32'(dstrobe), 32'd1);
        chk("R3", "no words before ack", 32'(got_q.size()), 32'd0);
        dmack = 1'b1;
        wait_got(4);
        finish_burst(4, "A");

        // burst B: 20 words with a host pause in the middle
        push_words(20, 16'h0F0F);
        host_rdy = 1'b1;
        step(3);
        dmack = 1'b1;
        wait_got(5);
        host_rdy = 1'b0;
        step(4);
        sa = got_q.size();
        step(6);
        sb = got_q.size();
        chk("R5", "paused host gets no words", 32'(sb), 32'(sa));
        chk("R5", "skid edges within three", 32'(pause_edges <= 3), 32'd1);
        host_rdy = 1'b1;
        wait_got(20);
        finish_burst(20, "B");

        // burst C: 7 words, source starves mid burst, odd count end
        push_words(7, 16'h1234);
        host_rdy = 1'b1;
        step(3);
        dmack = 1'b1;
        wait_got(3);
        gap = 1'b1;
        step(2);
        sa = got_q.size();
        step(8);
        chk("R6", "empty source holds strobe", 32'(got_q.size()), 32'(sa));
        gap = 1'b0;
        wait_got(7);
        chk("R7", "strobe low before stop", 32'(dstrobe), 32'd0);
        finish_burst(7, "C");

        // burst D: host stops while words remain
        push_words(10, 16'hBEEF);
        host_rdy = 1'b1;
        step(3);
        dmack = 1'b1;
        wait_got(3);
        stop = 1'b1;
        step(1);
        chk("R7", "no take while stopped", 32'(in_ready), 32'd0);
        sa = got_q.size();
        while (sent_q.size() > sa) void'(sent_q.pop_back());
        finish_burst(sa, "D");
        chk("R7", "unsent words kept at source", 32'(src_q.size() > 0), 32'd1);

        gap = 1'b1;
        step(4);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule